// File: doc/BRIEF.md
# Host Port Acknowledge and Packing Interface

This block is the slave side of a parallel host port. An external host selects it with one of two chip selects, one for memory or boot space and one for I/O space, and then runs strobed read and write cycles on an 8-bit or 16-bit data path. The block joins one, two or three of these narrow cycles into a single access of up to 24 bits on a wider internal bus. A read is fetched from the internal side on the first cycle of a word, and the later cycles are served from a local buffer. A write is gathered cycle by cycle and posted as one internal access on the last cycle.

One acknowledge line tells the host when a cycle may end. Its behaviour depends on a two-bit mode field. In ACK mode the line is idle low and rises only once the cycle can finish. In ready mode the line is idle high and drops to add wait states. A polarity bit can invert either behaviour. The ready/ACK choice is set at reset from two strap pins, and a configuration write can change it later. An address-phase cycle loads the low address bits, which a page register extends. The internal side is a one-cycle request carrying address, direction and space, and a done pulse that completes it.

Top module: `hostport_ack_pack`

## Requirements
- R1: While rst_n is low, the ready-mode bit loads 1 when strap_a equals strap_b and 0 when they differ, and the polarity-invert bit clears. After reset the idle hack level is therefore 1 in ready mode and 0 in ACK mode.
- R2: A cfg_wr with cfg_addr=0 loads the control field: bit 0 ready mode, bit 1 invert hack, bit 2 16-bit data path, bits 4:3 cycles per word (0 or 1 means one, 2 means two, 3 means three). A write with cfg_addr=1 loads the 8-bit page.
- R3: In ACK mode the active hack level appears one cycle after the strobe is first sampled for a cycle that needs no internal access. For a cycle that does need one, it appears one cycle after int_done. It stays active while the strobe is held and goes inactive one cycle after the strobe is released.
- R4: In ready mode hack is inactive from the first cycle a strobe is present until the cycle can complete, which is the same point as in R3. At all other times it is active.
- R5: A strobe with hale high is an address cycle. It is acknowledged one cycle later in either mode, loads hdata_in into the low address, issues no internal access and does not move the word position.
- R6: On the 8-bit path, position k carries word bits 8k+7:8k on hdata[7:0]. On the 16-bit path, position 0 carries bits 15:0 and position 1 carries bits 23:16 on hdata[7:0]. Any part of a lane that lies above bit 23 reads as zero and is discarded on a write.
- R7: A read at position 0 issues exactly one internal read and is acknowledged after int_done. Reads at later positions issue no request and are acknowledged one cycle later with buffered data.
- R8: Write cycles before the last position are acknowledged one cycle later with no request. The write at the last position issues one internal write of the assembled 24-bit word and is acknowledged after int_done.
- R9: int_req is a single-cycle pulse. It is issued with int_addr = {page, low address}, int_io high when hcs_io selected the cycle, and int_we high for a write.
- R10: The word position clears to 0 whenever both chip selects are low. It advances when the strobe of an acknowledged data cycle is released, and it wraps to 0 after the configured number of cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; host signals are synchronous to it |
| rst_n | input | 1 | Synchronous active-low reset |
| strap_a | input | 1 | Mode strap, sampled during reset |
| strap_b | input | 1 | Mode strap, sampled during reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects control, 1 selects page |
| cfg_wdata | input | 8 | Configuration write data |
| hcs_mem | input | 1 | Host select for memory/boot space |
| hcs_io | input | 1 | Host select for I/O space |
| hrd | input | 1 | Host read strobe |
| hwr | input | 1 | Host write strobe |
| hale | input | 1 | Marks the strobed cycle as an address cycle |
| hdata_in | input | 16 | Host write data or low address |
| hdata_out | output | 16 | Host read data for the current position |
| hack | output | 1 | Acknowledge / ready line |
| int_req | output | 1 | One-cycle internal access request |
| int_we | output | 1 | Internal access is a write |
| int_io | output | 1 | Internal access targets I/O space |
| int_addr | output | 24 | Internal address {page, low address} |
| int_wdata | output | 24 | Assembled write word |
| int_rdata | input | 24 | Internal read word |
| int_done | input | 1 | Internal access complete |

## Verification
The assertions assume that the host holds its strobe, chip select and direction steady until it sees the active acknowledge level. They also assume that the configuration is written only while both chip selects are low, and that int_done comes only after a request and once per request. The bench drives every host cycle through one task that waits for the acknowledge before it drops the strobe. It writes the configuration only between transfers, after the chip selects have been released. Its internal-memory model answers each request exactly once, with a latency that rotates from zero to three cycles.

// File: rtl/hp_pkg.sv
// Shared types for the host port acknowledge and packing interface.
// Assumes a word of at most three narrow host cycles (2-bit position).
package hp_pkg;

    // handshake state of one host strobe
    typedef enum logic [1:0] {
        HS_IDLE = 2'd0,
        HS_WAIT = 2'd1,
        HS_HOLD = 2'd2
    } hs_state_e;

    // control field as written at configuration address 0
    typedef struct packed {
        logic [1:0] beats;
        logic       wide16;
        logic       invert;
        logic       ready_mode;
    } hp_ctrl_t;

    localparam int CTRL_W = 5;
    localparam int POS_W  = 2;

endpackage

// File: rtl/hp_cfg_regs.sv
// Configuration storage: control field (handshake mode, polarity, path
// width, cycles per word) and target page. The ready-mode bit takes its
// value from the two straps on every reset cycle, and the invert bit
// clears. Assumes CFG_W >= PAGE_W and CFG_W >= CTRL_W.
module hp_cfg_regs
    import hp_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int CFG_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_a,
    input  logic              strap_b,
    input  logic              cfg_wr,
    input  logic              cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output hp_ctrl_t          ctrl,
    output logic [PAGE_W-1:0] page,
    output logic [POS_W-1:0]  last_idx
);

    // strap-loaded reset, then software rewrite of either register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl.ready_mode <= strap_a ~^ strap_b;
            ctrl.invert     <= 1'b0;
            ctrl.wide16     <= 1'b0;
            ctrl.beats      <= 2'd1;
            page            <= '0;
        end else if (cfg_wr) begin
            if (cfg_addr == 1'b0) begin
                ctrl <= hp_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            end else begin
                page <= cfg_wdata[PAGE_W-1:0];
            end
        end
    end

    // position index of the final cycle of a word
    always_comb begin
        case (ctrl.beats)
            2'd2:    last_idx = POS_W'(1);
            2'd3:    last_idx = POS_W'(2);
            default: last_idx = POS_W'(0);
        endcase
    end

endmodule

// File: rtl/hp_pack_dp.sv
// Packing datapath: keeps the word position, the 24-bit assembly/prefetch
// buffer, the low address and the attributes of the current cycle. It
// places host lanes into the word and selects the lane to read back.
// Assumes LO_W <= HW and that the host holds its data while strobing.
module hp_pack_dp
    import hp_pkg::*;
#(
    parameter int HW   = 16,
    parameter int IW   = 24,
    parameter int LO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wide16,
    input  logic [POS_W-1:0] last_idx,
    input  logic             cs_any,
    input  logic             cs_io_sel,
    input  logic             hwr,
    input  logic             hale,
    input  logic [HW-1:0]    hdata_in,
    input  logic             start,
    input  logic             finish,
    input  logic             rd_load,
    input  logic [IW-1:0]    int_rdata,
    output logic [HW-1:0]    hdata_out,
    output logic             need_acc,
    output logic [POS_W-1:0] pos,
    output logic [LO_W-1:0]  addr_lo,
    output logic [IW-1:0]    word,
    output logic             cur_we,
    output logic             cur_io
);

    localparam int EXT_W = IW + HW;
    localparam int OFF_W = $clog2(EXT_W);

    logic             cur_adr;
    logic [HW-1:0]    lane_mask;
    logic [OFF_W-1:0] lane_w;
    logic [OFF_W-1:0] off;
    logic [EXT_W-1:0] ins_ext;
    logic [EXT_W-1:0] msk_ext;
    logic [EXT_W-1:0] rd_ext;
    logic [IW-1:0]    merged;
    logic             unused_hi;

    // lane geometry for the selected path width and current position
    always_comb begin
        lane_mask = wide16 ? {HW{1'b1}} : HW'({(HW/2){1'b1}});
        lane_w    = wide16 ? OFF_W'(HW) : OFF_W'(HW/2);
        off       = OFF_W'(pos) * lane_w;
        ins_ext   = EXT_W'(hdata_in) << off;
        msk_ext   = EXT_W'(lane_mask) << off;
        rd_ext    = EXT_W'(word) >> off;
        merged    = (word & ~msk_ext[IW-1:0]) | (ins_ext[IW-1:0] & msk_ext[IW-1:0]);
        hdata_out = rd_ext[HW-1:0] & lane_mask;
        unused_hi = ^{ins_ext[EXT_W-1:IW], msk_ext[EXT_W-1:IW], rd_ext[EXT_W-1:HW]};
    end

    // an access is due on the first read cycle or the last write cycle
    always_comb begin
        need_acc = hwr ? (pos == last_idx) : (pos == POS_W'(0));
    end

    // word position: cleared without a select, stepped on strobe release
    always_ff @(posedge clk) begin
        if (!rst_n || !cs_any) begin
            pos <= '0;
        end else if (finish && !cur_adr) begin
            pos <= (pos == last_idx) ? '0 : pos + POS_W'(1);
        end
    end

    // attributes of the cycle being served, latched when its strobe is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_we  <= 1'b0;
            cur_io  <= 1'b0;
            cur_adr <= 1'b0;
        end else if (start) begin
            cur_we  <= hwr;
            cur_io  <= cs_io_sel;
            cur_adr <= hale;
        end
    end

    // word buffer: merge write lanes, or take the prefetched read word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word <= '0;
        end else if (start && !hale && hwr) begin
            word <= merged;
        end else if (rd_load) begin
            word <= int_rdata;
        end
    end

    // low address, loaded by address cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_lo <= '0;
        end else if (start && hale) begin
            addr_lo <= hdata_in[LO_W-1:0];
        end
    end

endmodule

// File: rtl/hp_handshake.sv
// Per-strobe handshake: takes a new strobe, issues a one-cycle internal
// request when the datapath asks for one, waits for done, then holds
// until the host releases the strobe. Builds the ACK-mode or ready-mode
// level and applies the polarity bit. Assumes the strobe is held until
// acknowledged and that done follows each request exactly once.
module hp_handshake
    import hp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic hale,
    input  logic need_acc,
    input  logic int_done,
    input  logic ready_mode,
    input  logic invert,
    output logic start,
    output logic finish,
    output logic waiting,
    output logic int_req,
    output logic hack_act,
    output logic hack
);

    hs_state_e state;

    // strobe events seen by the datapath
    always_comb begin
        start   = (state == HS_IDLE) && strobe;
        finish  = (state == HS_HOLD) && !strobe;
        waiting = (state == HS_WAIT);
    end

    // strobe sequencing: idle -> (wait for done) -> hold -> idle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= HS_IDLE;
        end else begin
            case (state)
                HS_IDLE: if (strobe) state <= (!hale && need_acc) ? HS_WAIT : HS_HOLD;
                HS_WAIT: if (int_done) state <= HS_HOLD;
                HS_HOLD: if (!strobe) state <= HS_IDLE;
                default: state <= HS_IDLE;
            endcase
        end
    end

    // one-cycle internal request on entry to the wait state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_req <= 1'b0;
        end else begin
            int_req <= start && !hale && need_acc;
        end
    end

    // acknowledge level: ACK mode asserts when done, ready mode drops while pending
    always_comb begin
        if (ready_mode) begin
            hack_act = !(strobe && (state != HS_HOLD));
        end else begin
            hack_act = (state == HS_HOLD);
        end
        hack = hack_act ^ invert;
    end

endmodule

// File: rtl/hostport_ack_pack.sv
// Host port acknowledge and packing interface, top level. Decodes the two
// chip selects, joins narrow host cycles into internal words and drives
// the acknowledge line. Assumes host signals are synchronous to clk and
// that configuration is written only while both chip selects are low.
module hostport_ack_pack
    import hp_pkg::*;
#(
    parameter int HW     = 16,
    parameter int IW     = 24,
    parameter int LO_W   = 16,
    parameter int PAGE_W = 8,
    parameter int CFG_W  = 8,
    localparam int AW    = PAGE_W + LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strap_a,
    input  logic             strap_b,
    input  logic             cfg_wr,
    input  logic             cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             hcs_mem,
    input  logic             hcs_io,
    input  logic             hrd,
    input  logic             hwr,
    input  logic             hale,
    input  logic [HW-1:0]    hdata_in,
    output logic [HW-1:0]    hdata_out,
    output logic             hack,
    output logic             int_req,
    output logic             int_we,
    output logic             int_io,
    output logic [AW-1:0]    int_addr,
    output logic [IW-1:0]    int_wdata,
    input  logic [IW-1:0]    int_rdata,
    input  logic             int_done
);

    hp_ctrl_t          ctrl;
    logic [PAGE_W-1:0] page;
    logic [POS_W-1:0]  last_idx;
    logic [POS_W-1:0]  pos;
    logic [LO_W-1:0]   addr_lo;
    logic              cs_any;
    logic              cs_io_sel;
    logic              strobe;
    logic              start;
    logic              finish;
    logic              waiting;
    logic              need_acc;
    logic              rd_load;
    logic              hack_act;
    logic              ready_mode;
    logic              invert;

    // select decode and strobe qualification
    always_comb begin
        cs_any     = hcs_mem || hcs_io;
        cs_io_sel  = hcs_io && !hcs_mem;
        strobe     = cs_any && (hrd || hwr);
        rd_load    = waiting && int_done && !int_we;
        ready_mode = ctrl.ready_mode;
        invert     = ctrl.invert;
        int_addr   = {page, addr_lo};
    end

    hp_cfg_regs #(
        .PAGE_W (PAGE_W),
        .CFG_W  (CFG_W)
    ) i_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_a   (strap_a),
        .strap_b   (strap_b),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .ctrl      (ctrl),
        .page      (page),
        .last_idx  (last_idx)
    );

    hp_pack_dp #(
        .HW   (HW),
        .IW   (IW),
        .LO_W (LO_W)
    ) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .wide16    (ctrl.wide16),
        .last_idx  (last_idx),
        .cs_any    (cs_any),
        .cs_io_sel (cs_io_sel),
        .hwr       (hwr),
        .hale      (hale),
        .hdata_in  (hdata_in),
        .start     (start),
        .finish    (finish),
        .rd_load   (rd_load),
        .int_rdata (int_rdata),
        .hdata_out (hdata_out),
        .need_acc  (need_acc),
        .pos       (pos),
        .addr_lo   (addr_lo),
        .word      (int_wdata),
        .cur_we    (int_we),
        .cur_io    (int_io)
    );

    hp_handshake i_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (strobe),
        .hale       (hale),
        .need_acc   (need_acc),
        .int_done   (int_done),
        .ready_mode (ready_mode),
        .invert     (invert),
        .start      (start),
        .finish     (finish),
        .waiting    (waiting),
        .int_req    (int_req),
        .hack_act   (hack_act),
        .hack       (hack)
    );

endmodule

// File: rtl/hp_ack_pack_chk.sv
// Property checker for hostport_ack_pack, attached by bind. Assumes the
// host holds its strobe until acknowledged and that configuration changes
// only while both chip selects are low.
module hp_ack_pack_chk
    import hp_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             strap_a,
    input logic             strap_b,
    input logic             hcs_mem,
    input logic             hcs_io,
    input logic             hrd,
    input logic             hwr,
    input logic             hale,
    input logic             hack,
    input logic             int_req,
    input logic             int_we,
    input logic             strobe,
    input logic             start,
    input logic             hack_act,
    input logic             ready_mode,
    input logic             invert,
    input logic [POS_W-1:0] pos,
    input logic [POS_W-1:0] last_idx
);

    assert_strap_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> ((ready_mode == ($past(strap_a) ~^ $past(strap_b))) && !invert));

    assert_ack_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_mode && int_req) |-> (hack == invert));

    assert_ack_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_mode && hack_act && strobe) |=> hack_act);

    assert_ready_wait_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_mode && int_req && strobe) |-> (hack == invert));

    assert_addr_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && hale) |=> (hack_act && !int_req));

    assert_read_buffered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !hale && hrd && !hwr && (pos != '0)) |=> !int_req);

    assert_write_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int_req && int_we) |-> (pos == last_idx));

    assert_req_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |=> !int_req);

    assert_pos_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hcs_mem && !hcs_io) |=> (pos == '0));

    assert_pos_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (hcs_mem || hcs_io) |-> (pos <= last_idx));

endmodule

bind hostport_ack_pack hp_ack_pack_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strap_a    (strap_a),
    .strap_b    (strap_b),
    .hcs_mem    (hcs_mem),
    .hcs_io     (hcs_io),
    .hrd        (hrd),
    .hwr        (hwr),
    .hale       (hale),
    .hack       (hack),
    .int_req    (int_req),
    .int_we     (int_we),
    .strobe     (strobe),
    .start      (start),
    .hack_act   (hack_act),
    .ready_mode (ready_mode),
    .invert     (invert),
    .pos        (pos),
    .last_idx   (last_idx)
);

// File: tb/test_hostport_ack_pack.sv
// Self-checking bench: a vector table of host cycles in ACK mode, then
// directed tests for reset straps, polarity, ready mode, the 16-bit path
// and position clearing.
module test_hostport_ack_pack;

    typedef struct packed {
        logic        io;
        logic [1:0]  kind;   // 0 address, 1 write, 2 read
        logic [15:0] din;
        logic [15:0] exp;
        logic        req;
        logic        drop;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 16'h0005, 16'h0000, 1'b0, 1'b0},
        '{1'b0, 2'd1, 16'h0011, 16'h0000, 1'b0, 1'b0},
        '{1'b0, 2'd1, 16'h0022, 16'h0000, 1'b0, 1'b0},
        '{1'b0, 2'd1, 16'h0033, 16'h0000, 1'b1, 1'b0},
        '{1'b0, 2'd2, 16'h0000, 16'h0011, 1'b1, 1'b0},
        '{1'b0, 2'd2, 16'h0000, 16'h0022, 1'b0, 1'b0},
        '{1'b0, 2'd2, 16'h0000, 16'h0033, 1'b0, 1'b1},
        '{1'b1, 2'd0, 16'h0009, 16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd1, 16'h00A1, 16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd1, 16'h00B2, 16'h0000, 1'b0, 1'b0},
        '{1'b1, 2'd1, 16'h00C3, 16'h0000, 1'b1, 1'b0},
        '{1'b1, 2'd2, 16'h0000, 16'h00A1, 1'b1, 1'b0},
        '{1'b1, 2'd2, 16'h0000, 16'h00B2, 1'b0, 1'b0},
        '{1'b1, 2'd2, 16'h0000, 16'h00C3, 1'b0, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_a = 1'b0, strap_b = 1'b0;
    logic        cfg_wr = 1'b0, cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        hcs_mem = 1'b0, hcs_io = 1'b0, hrd = 1'b0, hwr = 1'b0, hale = 1'b0;
    logic [15:0] hdata_in = '0;
    logic [15:0] hdata_out;
    logic        hack, int_req, int_we, int_io, int_done = 1'b0;
    logic [23:0] int_addr, int_wdata, int_rdata = '0;

    int n_vec = 0;
    int n_bad = 0;
    int req_cnt = 0;
    logic [23:0] mem [16];
    logic [23:0] last_addr = '0;
    logic        last_io = 1'b0, last_we = 1'b0;
    logic        act_lvl = 1'b1, idle_lvl = 1'b0, rdy_mode = 1'b0;

    hostport_ack_pack i_hostport_ack_pack (
        .clk(clk), .rst_n(rst_n), .strap_a(strap_a), .strap_b(strap_b),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .hcs_mem(hcs_mem), .hcs_io(hcs_io), .hrd(hrd), .hwr(hwr), .hale(hale),
        .hdata_in(hdata_in), .hdata_out(hdata_out), .hack(hack),
        .int_req(int_req), .int_we(int_we), .int_io(int_io), .int_addr(int_addr),
        .int_wdata(int_wdata), .int_rdata(int_rdata), .int_done(int_done)
    );

    initial forever #2ns clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // internal memory model with rotating done latency 0..3
    initial begin
        int lat_seq = 0;
        for (int i = 0; i < 16; i++) mem[i] = '0;
        forever begin
            @(negedge clk);
            if (int_req) begin
                req_cnt++;
                last_addr = int_addr;
                last_io   = int_io;
                last_we   = int_we;
                repeat (lat_seq) @(negedge clk);
                lat_seq = (lat_seq + 1) % 4;
                if (last_we) mem[last_addr[3:0]] = int_wdata;
                else int_rdata = mem[last_addr[3:0]];
                int_done = 1'b1;
                @(negedge clk);
                int_done = 1'b0;
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic set_mode(input logic rdy, input logic inv);
        rdy_mode = rdy;
        act_lvl  = ~inv;
        idle_lvl = rdy ? ~inv : inv;
    endtask

    task automatic do_reset(input logic a, input logic b);
        @(negedge clk);
        rst_n = 1'b0; strap_a = a; strap_b = b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg(input logic a, input logic [7:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic cs_off();
        @(negedge clk);
        hcs_mem = 1'b0; hcs_io = 1'b0;
    endtask

    // one host cycle: strobe, wait for acknowledge, capture, release
    task automatic host_cyc(input logic io, input logic [1:0] kind, input logic [15:0] din,
                            output logic [15:0] dout, output int waits, output logic first_lvl);
        @(negedge clk);
        hcs_mem = ~io; hcs_io = io;
        hale = (kind == 2'd0); hwr = (kind != 2'd2); hrd = (kind == 2'd2);
        hdata_in = din;
        #1ns first_lvl = hack;
        waits = 0;
        do begin
            @(posedge clk);
            #1ns waits++;
        end while (hack !== act_lvl && waits < 64);
        if (waits >= 64) chk("R3 ack timeout", 32'(waits), 32'd0);
        dout = hdata_out;
        @(negedge clk);
        hrd = 1'b0; hwr = 1'b0; hale = 1'b0;
        @(posedge clk);
        #1ns;
        if (rdy_mode) chk("R4 level after release", 32'(hack), 32'(idle_lvl));
        else chk("R3 inactive after release", 32'(hack), 32'(idle_lvl));
    endtask

    initial begin
        logic [15:0] dout;
        int waits;
        logic fl;
        int rc0;

        // R1: straps equal -> ready mode, idle high
        do_reset(1'b1, 1'b1);
        chk("R1 equal straps idle level", 32'(hack), 32'd1);
        // R2: invert bit flips the idle level
        cfg(1'b0, 8'h03);
        #1ns chk("R2 inverted ready idle", 32'(hack), 32'd0);
        // R1: reset clears invert, equal straps again ready
        do_reset(1'b0, 1'b0);
        chk("R1 invert cleared, ready idle", 32'(hack), 32'd1);
        // R1: differing straps -> ACK mode, idle low
        do_reset(1'b0, 1'b1);
        chk("R1 differing straps idle level", 32'(hack), 32'd0);

        // R2: 8-bit path, three cycles per word, ACK mode; page 0x2A
        cfg(1'b0, 8'h18);
        cfg(1'b1, 8'h2A);
        set_mode(1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            string tg;
            tg = (VECS[i].kind == 2'd0) ? "R5" : (VECS[i].kind == 2'd1) ? "R8" : "R7";
            rc0 = req_cnt;
            host_cyc(VECS[i].io, VECS[i].kind, VECS[i].din, dout, waits, fl);
            if (VECS[i].kind == 2'd2) chk({"R6 read lane ", tg}, 32'(dout), 32'(VECS[i].exp));
            chk({tg, " request count"}, 32'(req_cnt - rc0), 32'(VECS[i].req));
            chk({tg, " R3 ack delay"}, 32'(waits == 1), 32'(!VECS[i].req));
            if (VECS[i].drop) cs_off();
        end

        chk("R8 posted word mem", 32'(mem[5]), 32'h00332211);
        chk("R8 posted word io", 32'(mem[9]), 32'h00C3B2A1);
        chk("R9 request address", 32'(last_addr), 32'h002A0009);
        chk("R9 io space flag", 32'(last_io), 32'd1);
        chk("R9 read direction", 32'(last_we), 32'd0);

        // R10: a dropped select restarts packing at position 0
        host_cyc(1'b0, 2'd0, 16'h0004, dout, waits, fl);
        host_cyc(1'b0, 2'd1, 16'h0077, dout, waits, fl);
        cs_off();
        rc0 = req_cnt;
        host_cyc(1'b0, 2'd1, 16'h0001, dout, waits, fl);
        host_cyc(1'b0, 2'd1, 16'h0002, dout, waits, fl);
        host_cyc(1'b0, 2'd1, 16'h0003, dout, waits, fl);
        cs_off();
        chk("R10 restart after deselect", 32'(mem[4]), 32'h00030201);
        chk("R10 single write request", 32'(req_cnt - rc0), 32'd1);
        chk("R9 memory space flag", 32'(last_io), 32'd0);

        // R4/R6: ready mode, 16-bit path, three cycles per word
        cfg(1'b0, 8'h1D);
        set_mode(1'b1, 1'b0);
        #1ns chk("R4 ready idle level", 32'(hack), 32'd1);
        host_cyc(1'b0, 2'd0, 16'h0003, dout, waits, fl);
        chk("R5 address ack in ready mode", 32'(waits), 32'd1);
        chk("R4 first strobe cycle low", 32'(fl), 32'd0);
        host_cyc(1'b0, 2'd1, 16'h5678, dout, waits, fl);
        chk("R8 early write beat", 32'(waits), 32'd1);
        host_cyc(1'b0, 2'd1, 16'h009A, dout, waits, fl);
        chk("R8 middle write beat", 32'(waits), 32'd1);
        host_cyc(1'b0, 2'd1, 16'hFFFF, dout, waits, fl);
        chk("R4 wait state on final write", 32'(waits > 1), 32'd1);
        chk("R6 16-bit word assembled", 32'(mem[3]), 32'h009A5678);
        host_cyc(1'b0, 2'd2, 16'h0000, dout, waits, fl);
        chk("R4 wait state on prefetch", 32'(waits > 1), 32'd1);
        chk("R6 16-bit lane 0", 32'(dout), 32'h5678);
        host_cyc(1'b0, 2'd2, 16'h0000, dout, waits, fl);
        chk("R6 16-bit lane 1", 32'(dout), 32'h009A);
        host_cyc(1'b0, 2'd2, 16'h0000, dout, waits, fl);
        chk("R6 lane past bit 23", 32'(dout), 32'h0000);
        chk("R7 buffered read delay", 32'(waits), 32'd1);
        cs_off();

        finish_run();
    end

endmodule